// File: doc/BRIEF.md
# Half-Bridge Undervoltage Lockout Gate

This block sits between a controller's two drive commands and the gate-driver output stage of one half-bridge leg. It watches two supply rails, each delivered as a sampled digital voltage code. The first is the shared logic rail that powers both channels. The second is the floating rail that powers only the high side. Each rail is qualified by its own hysteresis state machine. A rail becomes good when its code reaches a rising threshold. It becomes bad again only when its code drops below a lower falling threshold.

The logic rail gates both channels and the active-low fault output. The floating rail gates only the high-side channel. A third state machine watches a synchronised flag that marks a negative excursion of the switch node. When that flag stays high long enough, the state machine blanks the high-side output for a fixed hold window. A fresh qualifying excursion during the window starts the window again.

The drive commands pass to the outputs in phase and in the same cycle whenever no lockout applies.

Per-rail states: `RAIL_BAD` and `RAIL_GOOD`.
- `RAIL_BAD` goes to `RAIL_GOOD` on the transition *rail qualifies*, when code >= RISE_TH.
- `RAIL_GOOD` goes to `RAIL_BAD` on the transition *rail drops*, when code < FALL_TH.

Excursion states: `BLK_IDLE`, `BLK_QUAL` and `BLK_HOLD`.
- *flag seen*: `BLK_IDLE` goes to `BLK_QUAL` when the flag is high.
- *flag gone*: `BLK_QUAL` goes to `BLK_IDLE` when the flag drops before it qualifies.
- *qualified*: `BLK_IDLE` or `BLK_QUAL` goes to `BLK_HOLD` when the flag has been high for QUAL_CYC consecutive edges.
- *retrigger*: `BLK_HOLD` stays in `BLK_HOLD` and reloads the hold counter on a new qualification.
- *hold expired*: `BLK_HOLD` goes to `BLK_IDLE` when the hold counter reaches zero.

Drive modes, derived from the states above: `DRV_LOCKED`, `DRV_LOW_ONLY` and `DRV_BOTH`.

Top module: `hb_uvlo_gate`

## Requirements
- R1: While reset is asserted, and after reset until the logic rail first qualifies, ho = 0, lo = 0 and fault_n = 0, whatever hin and lin are.
- R2: A rail in the bad state becomes good on the first clock edge that samples its code >= RISE_TH (default 712). A code of RISE_TH-1 does not qualify it.
- R3: A rail in the good state becomes bad on the first clock edge that samples its code < FALL_TH (default 616). A code equal to FALL_TH keeps it good.
- R4: A code in the band FALL_TH <= code < RISE_TH leaves the rail state unchanged, whether that state is good or bad.
- R5: While the logic rail is bad, ho = 0, lo = 0 and fault_n = 0.
- R6: While the logic rail is good and the floating rail is bad, ho = 0, lo = lin and fault_n = 1.
- R7: If neg_flag is sampled high on QUAL_CYC consecutive edges (default 5), ho is forced to 0 from that edge for exactly HOLD_CYC cycles (default 450). A run of QUAL_CYC-1 high samples has no effect on ho.
- R8: A new qualifying excursion during the hold window restarts the window, so ho stays 0 for HOLD_CYC cycles counted from the new qualifying edge.
- R9: With both rails good and no hold window active, ho = hin and lo = lin in the same cycle.
- R10: The excursion hold window affects neither lo, which follows lin, nor fault_n, which stays 1 while the logic rail is good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| logic_code | input | CODE_W | Sampled logic-rail voltage code |
| float_code | input | CODE_W | Sampled floating-rail voltage code |
| neg_flag | input | 1 | Synchronised negative switch-node excursion flag |
| hin | input | 1 | High-side drive command |
| lin | input | 1 | Low-side drive command |
| ho | output | 1 | Gated high-side drive enable |
| lo | output | 1 | Gated low-side drive enable |
| fault_n | output | 1 | Active-low logic-rail undervoltage fault |

## Verification
The assertions assume the following about the inputs:
- Both voltage codes are already synchronous to clk, free of X, and meaningful as a new sample on every edge.
- neg_flag has already been synchronised.
- hin and lin change only between edges, since they reach the outputs combinationally.

The stimulus meets these conditions by changing every input only at the falling edge, after reset is released. It holds each rail code for whole cycles, with values placed exactly on and one step either side of both thresholds.

// File: rtl/hbu_pkg.sv
package hbu_pkg;

    typedef enum logic {
        RAIL_BAD  = 1'b0,
        RAIL_GOOD = 1'b1
    } rail_st_t;

    typedef enum logic [1:0] {
        BLK_IDLE = 2'd0,
        BLK_QUAL = 2'd1,
        BLK_HOLD = 2'd2
    } blk_st_t;

    typedef enum logic [1:0] {
        DRV_LOCKED   = 2'd0,
        DRV_LOW_ONLY = 2'd1,
        DRV_BOTH     = 2'd2
    } drv_mode_t;

endpackage

// File: rtl/hbu_rail_hyst.sv
module hbu_rail_hyst
    import hbu_pkg::*;
#(
    parameter int CODE_W  = 10,
    parameter int RISE_TH = 712,
    parameter int FALL_TH = 616
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    output logic              good
);

    localparam logic [CODE_W-1:0] RISE_C = CODE_W'(RISE_TH);
    localparam logic [CODE_W-1:0] FALL_C = CODE_W'(FALL_TH);

    rail_st_t state_q;
    rail_st_t state_d;

    // Next-state logic: qualify at or above RISE_C, drop below FALL_C.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RAIL_BAD: begin
                if (code >= RISE_C) state_d = RAIL_GOOD;
            end
            RAIL_GOOD: begin
                if (code < FALL_C) state_d = RAIL_BAD;
            end
            default: state_d = RAIL_BAD;
        endcase
    end

    // State register: a rail starts out bad after reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RAIL_BAD;
        else        state_q <= state_d;
    end

    // Output decode.
    always_comb begin
        unique case (state_q)
            RAIL_GOOD: good = 1'b1;
            default:   good = 1'b0;
        endcase
    end

    assert_rise_qualifies_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!good && code >= RISE_C) |=> good);

    assert_fall_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (good && code < FALL_C) |=> !good);

    assert_band_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (code >= FALL_C && code < RISE_C) |=> $stable(good));

endmodule

// File: rtl/hbu_neg_blank.sv
module hbu_neg_blank
    import hbu_pkg::*;
#(
    parameter int QUAL_CYC = 5,
    parameter int HOLD_CYC = 450
) (
    input  logic clk,
    input  logic rst_n,
    input  logic neg_flag,
    output logic blank
);

    localparam int QW = $clog2(QUAL_CYC + 1);
    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam logic [QW-1:0] QUAL_LAST = QW'(QUAL_CYC - 1);
    localparam logic [QW-1:0] QUAL_SAT  = QW'(QUAL_CYC);
    localparam logic [HW-1:0] HOLD_LOAD = HW'(HOLD_CYC - 1);
    localparam logic [HW-1:0] HOLD_LIM  = HW'(HOLD_CYC);

    blk_st_t       state_q;
    blk_st_t       state_d;
    logic [QW-1:0] qcnt_q;
    logic [QW-1:0] qcnt_d;
    logic [HW-1:0] hcnt_q;
    logic [HW-1:0] hcnt_d;
    logic          qual_hit;

    // Count consecutive high samples of the flag. The count saturates, so a
    // flag that stays high qualifies only once.
    always_comb begin
        if (!neg_flag)              qcnt_d = '0;
        else if (qcnt_q != QUAL_SAT) qcnt_d = qcnt_q + 1'b1;
        else                        qcnt_d = qcnt_q;
    end

    assign qual_hit = neg_flag && (qcnt_q == QUAL_LAST);

    // Next-state logic for the excursion state machine.
    always_comb begin
        state_d = state_q;
        hcnt_d  = hcnt_q;
        unique case (state_q)
            BLK_IDLE: begin
                if (qual_hit) begin
                    state_d = BLK_HOLD;
                    hcnt_d  = HOLD_LOAD;
                end else if (neg_flag) begin
                    state_d = BLK_QUAL;
                end
            end
            BLK_QUAL: begin
                if (qual_hit) begin
                    state_d = BLK_HOLD;
                    hcnt_d  = HOLD_LOAD;
                end else if (!neg_flag) begin
                    state_d = BLK_IDLE;
                end
            end
            BLK_HOLD: begin
                if (qual_hit) begin
                    hcnt_d = HOLD_LOAD;
                end else if (hcnt_q == '0) begin
                    state_d = BLK_IDLE;
                end else begin
                    hcnt_d = hcnt_q - 1'b1;
                end
            end
            default: begin
                state_d = BLK_IDLE;
                hcnt_d  = '0;
            end
        endcase
    end

    // State and counter registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BLK_IDLE;
            qcnt_q  <= '0;
            hcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            qcnt_q  <= qcnt_d;
            hcnt_q  <= hcnt_d;
        end
    end

    // Output decode.
    always_comb begin
        unique case (state_q)
            BLK_HOLD: blank = 1'b1;
            default:  blank = 1'b0;
        endcase
    end

    assert_blank_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blank) |-> $past(neg_flag));

    assert_hold_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> (hcnt_q < HOLD_LIM));

    assert_retrigger_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (blank && qual_hit) |=> (blank && hcnt_q == HOLD_LOAD));

endmodule

// File: rtl/hb_uvlo_gate.sv
module hb_uvlo_gate
    import hbu_pkg::*;
#(
    parameter int CODE_W   = 10,
    parameter int RISE_TH  = 712,
    parameter int FALL_TH  = 616,
    parameter int QUAL_CYC = 5,
    parameter int HOLD_CYC = 450
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] logic_code,
    input  logic [CODE_W-1:0] float_code,
    input  logic              neg_flag,
    input  logic              hin,
    input  logic              lin,
    output logic              ho,
    output logic              lo,
    output logic              fault_n
);

    logic      logic_good;
    logic      float_good;
    logic      blank;
    drv_mode_t mode;

    hbu_rail_hyst #(
        .CODE_W (CODE_W),
        .RISE_TH(RISE_TH),
        .FALL_TH(FALL_TH)
    ) u_logic_rail (
        .clk  (clk),
        .rst_n(rst_n),
        .code (logic_code),
        .good (logic_good)
    );

    hbu_rail_hyst #(
        .CODE_W (CODE_W),
        .RISE_TH(RISE_TH),
        .FALL_TH(FALL_TH)
    ) u_float_rail (
        .clk  (clk),
        .rst_n(rst_n),
        .code (float_code),
        .good (float_good)
    );

    hbu_neg_blank #(
        .QUAL_CYC(QUAL_CYC),
        .HOLD_CYC(HOLD_CYC)
    ) u_neg_blank (
        .clk     (clk),
        .rst_n   (rst_n),
        .neg_flag(neg_flag),
        .blank   (blank)
    );

    // Drive mode: a logic-rail fault dominates. A floating-rail fault or a
    // hold window removes only the high side.
    always_comb begin
        if (!logic_good)                mode = DRV_LOCKED;
        else if (!float_good || blank)  mode = DRV_LOW_ONLY;
        else                            mode = DRV_BOTH;
    end

    // Output process.
    always_comb begin
        unique case (mode)
            DRV_BOTH: begin
                ho      = hin;
                lo      = lin;
                fault_n = 1'b1;
            end
            DRV_LOW_ONLY: begin
                ho      = 1'b0;
                lo      = lin;
                fault_n = 1'b1;
            end
            default: begin
                ho      = 1'b0;
                lo      = 1'b0;
                fault_n = 1'b0;
            end
        endcase
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> (!ho && !lo && !fault_n));

    assert_logic_lockout_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !logic_good |-> (!ho && !lo && !fault_n));

    assert_float_lockout_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (logic_good && !float_good) |-> (!ho && lo == lin && fault_n));

    assert_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (logic_good && float_good && !blank) |-> (ho == hin && lo == lin));

    assert_blank_high_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (logic_good && blank) |-> (!ho && lo == lin && fault_n));

endmodule

// File: tb/hb_uvlo_gate_test.sv
module hb_uvlo_gate_test;

    localparam int CODE_W = 10;
    localparam int HOLD   = 450;

    typedef struct {
        logic  ho;
        logic  lo;
        logic  fn;
        string tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CODE_W-1:0] logic_code = '0;
    logic [CODE_W-1:0] float_code = '0;
    logic              neg_flag = 1'b0;
    logic              hin = 1'b0;
    logic              lin = 1'b0;
    logic              ho;
    logic              lo;
    logic              fault_n;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t sb[$];
    int   vc = 0;
    int   vb = 0;

    always #10 clk = ~clk;

    hb_uvlo_gate uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .logic_code(logic_code),
        .float_code(float_code),
        .neg_flag  (neg_flag),
        .hin       (hin),
        .lin       (lin),
        .ho        (ho),
        .lo        (lo),
        .fault_n   (fault_n)
    );

    task automatic compare(input logic eho, input logic elo, input logic efn, input string tag);
        checks++;
        if (ho !== eho || lo !== elo || fault_n !== efn) begin
            errors++;
            $display("FAIL %s: ho/lo/fault_n = %b%b%b, expected %b%b%b",
                     tag, ho, lo, fault_n, eho, elo, efn);
        end
    endtask

    // Driver: set inputs at the falling edge and queue the outputs expected
    // after the following rising edge.
    task automatic step(input logic n, input logic h, input logic l,
                        input logic eho, input logic elo, input logic efn,
                        input string tag);
        exp_t e;
        @(negedge clk);
        logic_code = CODE_W'(vc);
        float_code = CODE_W'(vb);
        neg_flag   = n;
        hin        = h;
        lin        = l;
        e.ho = eho; e.lo = elo; e.fn = efn; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare a quarter period after each rising edge.
    always @(posedge clk) begin
        #5;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            compare(e.ho, e.lo, e.fn, e.tag);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: outputs quiet during reset.
        hin = 1'b1; lin = 1'b1;
        #25;
        compare(1'b0, 1'b0, 1'b0, "R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;

        // R1: no drive after reset until the logic rail qualifies.
        vc = 0; vb = 800;
        step(0, 1, 1, 0, 0, 0, "R1 after reset");
        step(0, 1, 0, 0, 0, 0, "R1 after reset");

        // R2: one code below the rising threshold does not qualify.
        vc = 711;
        step(0, 1, 1, 0, 0, 0, "R2 below rise");
        // R2: code at the threshold qualifies; floating rail good too.
        vc = 712; vb = 712;
        step(0, 1, 1, 1, 1, 1, "R2 at rise");

        // R9: both channels follow their inputs.
        step(0, 0, 0, 0, 0, 1, "R9 00");
        step(0, 1, 0, 1, 0, 1, "R9 10");
        step(0, 0, 1, 0, 1, 1, "R9 01");
        step(0, 1, 1, 1, 1, 1, "R9 11");

        // R4 and R3: the falling threshold itself keeps the rail good.
        vc = 616;
        step(0, 1, 1, 1, 1, 1, "R4 at fall");
        vc = 700;
        step(0, 1, 0, 1, 0, 1, "R4 band good");
        // R3 and R5: one below the falling threshold locks both channels.
        vc = 615;
        step(0, 1, 1, 0, 0, 0, "R3 R5 below fall");
        vc = 700;
        step(0, 1, 1, 0, 0, 0, "R4 band bad");
        step(0, 0, 1, 0, 0, 0, "R5 locked");
        vc = 712;
        step(0, 1, 1, 1, 1, 1, "R2 requalify");

        // R6: a floating-rail fault removes only the high side.
        vb = 615;
        step(0, 1, 1, 0, 1, 1, "R6 float bad");
        step(0, 1, 0, 0, 0, 1, "R6 lo follows");
        vb = 711;
        step(0, 1, 1, 0, 1, 1, "R4 float band bad");
        vb = 720;
        step(0, 1, 1, 1, 1, 1, "R2 float good");

        // R7: an excursion one sample too short has no effect.
        vc = 800; vb = 800;
        for (int i = 0; i < 4; i++)
            step(1, 1, 0, 1, 0, 1, "R7 short pulse");
        step(0, 1, 0, 1, 0, 1, "R7 short pulse");
        step(0, 1, 0, 1, 0, 1, "R7 short pulse");

        // R7: a qualifying excursion starts the hold on its fifth sample.
        for (int i = 0; i < 5; i++)
            step(1, 1, 0, (i == 4) ? 1'b0 : 1'b1, 0, 1, "R7 qualify");
        // R7 and R10: the hold lasts HOLD cycles; lo and fault_n untouched.
        for (int j = 1; j <= HOLD; j++)
            step(0, 1, j[0], (j == HOLD) ? 1'b1 : 1'b0, j[0], 1, "R7 R10 hold");

        // R8: a new excursion inside the hold restarts the window.
        for (int i = 0; i < 5; i++)
            step(1, 1, 0, (i == 4) ? 1'b0 : 1'b1, 0, 1, "R8 first");
        for (int j = 1; j <= 554; j++)
            step((j >= 100 && j <= 104) ? 1'b1 : 1'b0, 1, 1,
                 (j >= 554) ? 1'b1 : 1'b0, 1, 1, "R8 retrigger");

        // R5: a logic-rail fault during normal running.
        vc = 600;
        step(0, 1, 1, 0, 0, 0, "R5 final lock");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule